// File: doc/BRIEF.md
# Sync-Referenced Raster Timing Generator

This block produces the line and frame timing for a raster display: horizontal and vertical sync, a border (unblanked) window, an active-display window, a hardware-cursor window and the pixel coordinates inside the display window. Every count is measured from the leading edge of sync. Each line runs in this order: sync, back border, display, front border. The frame follows the same order in lines.

Geometry is set through a small write-only register port. Each horizontal register carries its own fixed offset and alignment. Each vertical register holds its line number minus one. Writes go into a shadow copy, which is adopted only at a frame boundary, so a change of mode never splits a frame.

Three control pins come from an external video control word, where they sit at bits 12, 16 and 18:
- run enable (bit 12);
- negative horizontal sync (bit 16);
- negative vertical sync (bit 18).

A one-cycle pulse at each frame start gives software a safe point at which to move the scroll origin.

Top module: `raster_timing_gen`

## Requirements
- R1: While `video_run` is 0, including after reset, the outputs `border_en`, `disp_en`, `cursor_win`, `frame_pulse`, `pix_x` and `pix_y` are 0. In the same condition `hsync` equals `hsync_neg` and `vsync` equals `vsync_neg`; right after reset both syncs are 0. When `video_run` rises, the first output cycle is line 0, position 0.
- R2: A line lasts `(reg0 with bits [1:0] cleared) + 8` cycles. `hsync` is active for positions below `(reg1 & ~1) + 8`.
- R3: The horizontal border window is `[(reg2&~1)+12, (reg5&~1)+12)`. The horizontal display window is `[(reg3&~1)+18, (reg4&~1)+18)`. Bit 0 of registers 1 to 5 and bits [1:0] of register 0 are ignored.
- R4: A frame lasts `reg7+1` lines and `vsync` is active on lines below `reg8+1`. The vertical border window is `[reg9+1, reg12+1)` and the vertical display window is `[reg10+1, reg11+1)`.
- R5: `disp_en` is 1 only when both display windows are open. `border_en` is 1 only when both border windows are open.
- R6: `cursor_win` is 1 for positions in `[reg6+17, reg6+17+CUR_W)` on lines in `[reg13+1, reg14+1)`. Register 6 uses every bit.
- R7: While `disp_en` is 1, `pix_x` is the position minus the display start and `pix_y` is the line minus the display start line. Otherwise both are 0.
- R8: `hsync_neg` = 1 inverts `hsync`, and `vsync_neg` = 1 inverts `vsync` (active level low).
- R9: `frame_pulse` is 1 for exactly the one output cycle that shows line 0, position 0. It therefore repeats once per frame of line-length times line-count cycles.
- R10: While running, a register write takes effect from the first cycle of the next frame, and the current frame keeps the old geometry. While `video_run` is 0, a write takes effect at once. Addresses 0 to 14 are used; address 15 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per pixel |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index (0-6 horizontal, 7-14 vertical) |
| cfg_wdata | input | DW | Register write data |
| video_run | input | 1 | Video enable (control word bit 12) |
| hsync_neg | input | 1 | Negative horizontal sync (control word bit 16) |
| vsync_neg | input | 1 | Negative vertical sync (control word bit 18) |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| border_en | output | 1 | Unblanked (border or display) region |
| disp_en | output | 1 | Active display region |
| cursor_win | output | 1 | Cursor window open |
| frame_pulse | output | 1 | One cycle at frame start |
| pix_x | output | DW+1 | Pixel column inside display |
| pix_y | output | DW+1 | Pixel row inside display |

## Verification
The hardest case is a register write that lands in the middle of a running frame. The design must keep the old geometry for the rest of that frame and switch to the new geometry exactly at the wrap, so the bench issues the write on a chosen cycle inside a frame it is already checking. It compares every cycle of that frame against the old expected geometry and every cycle of the next frame against the new one. Alignment masking is reached by writing odd and unaligned values while the video is stopped, then comparing a full frame against the aligned expectation.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int ADDR_W = 4;
  localparam int NREG   = 15;

  typedef enum logic [ADDR_W-1:0] {
    RG_HTOT = 4'd0,  RG_HSW  = 4'd1,  RG_HBS  = 4'd2,  RG_HDS  = 4'd3,
    RG_HDE  = 4'd4,  RG_HBE  = 4'd5,  RG_HCS  = 4'd6,  RG_VTOT = 4'd7,
    RG_VSW  = 4'd8,  RG_VBS  = 4'd9,  RG_VDS  = 4'd10, RG_VDE  = 4'd11,
    RG_VBE  = 4'd12, RG_VCS  = 4'd13, RG_VCE  = 4'd14
  } reg_id_e;

  // fixed offsets between register value and true position
  localparam int OFS_HTOT  = 8;
  localparam int OFS_HSYNC = 8;
  localparam int OFS_HBORD = 12;
  localparam int OFS_HDISP = 18;
  localparam int OFS_HCUR  = 17;
  localparam int OFS_VERT  = 1;

  typedef enum int {
    W_HS = 0, W_HB = 1, W_HD = 2, W_HC = 3,
    W_VS = 4, W_VB = 5, W_VD = 6, W_VC = 7
  } win_e;
  localparam int NWIN = 8;
endpackage

// File: rtl/rtg_regfile.sv
module rtg_regfile
  import rtg_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DW-1:0]                 wdata,
  input  logic                          load,
  output logic [NREG-1:0][DW-1:0]       active
);
  logic [NREG-1:0][DW-1:0] shadow;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DW-1:0] MASK =
      (i == int'(RG_HTOT)) ? ~DW'(3) :
      ((i >= int'(RG_HSW)) && (i <= int'(RG_HBE))) ? ~DW'(1) : '1;

    always_ff @(posedge clk) begin
      if (rst) begin
        shadow[i] <= '0;
      end else if (we && addr == ADDR_W'(i)) begin
        shadow[i] <= wdata & MASK;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        active[i] <= '0;
      end else if (load) begin
        active[i] <= shadow[i];
      end
    end
  end
endmodule

// File: rtl/rtg_counter.sv
module rtg_counter #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] last,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  assign wrap = step && (cnt >= last);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= wrap ? '0 : cnt + W'(1);
    end
  end
endmodule

// File: rtl/rtg_window.sv
module rtg_window #(
  parameter int W = 13
) (
  input  logic [W-1:0] pos,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic         open
);
  assign open = (pos >= lo) && (pos < hi);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int DW    = 12,
  parameter int CUR_W = 16,
  localparam int CW   = DW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic              video_run,
  input  logic              hsync_neg,
  input  logic              vsync_neg,
  output logic              hsync,
  output logic              vsync,
  output logic              border_en,
  output logic              disp_en,
  output logic              cursor_win,
  output logic              frame_pulse,
  output logic [CW-1:0]     pix_x,
  output logic [CW-1:0]     pix_y
);
  logic [NREG-1:0][DW-1:0] cfg;
  logic                    load;
  logic [CW-1:0]           hc, vc;
  logic                    h_wrap, v_wrap;
  logic [CW-1:0]           h_last, v_last;
  logic [CW-1:0]           win_pos [NWIN];
  logic [CW-1:0]           win_lo  [NWIN];
  logic [CW-1:0]           win_hi  [NWIN];
  logic [NWIN-1:0]         win_open;
  logic [CW-1:0]           hds_pos, vds_pos, hcur_lo;

  // shadow/active register set; adopt new geometry at frame wrap or when idle
  assign load = !video_run || v_wrap;

  rtg_regfile #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .load(load), .active(cfg)
  );

  function automatic logic [CW-1:0] ext(input logic [DW-1:0] v);
    return {1'b0, v};
  endfunction

  assign h_last  = ext(cfg[RG_HTOT]) + CW'(OFS_HTOT - 1);
  assign v_last  = ext(cfg[RG_VTOT]);
  assign hds_pos = ext(cfg[RG_HDS]) + CW'(OFS_HDISP);
  assign vds_pos = ext(cfg[RG_VDS]) + CW'(OFS_VERT);
  assign hcur_lo = ext(cfg[RG_HCS]) + CW'(OFS_HCUR);

  rtg_counter #(.W(CW)) u_hcnt (
    .clk(clk), .rst(rst), .clr(!video_run), .step(video_run),
    .last(h_last), .cnt(hc), .wrap(h_wrap)
  );

  rtg_counter #(.W(CW)) u_vcnt (
    .clk(clk), .rst(rst), .clr(!video_run), .step(h_wrap),
    .last(v_last), .cnt(vc), .wrap(v_wrap)
  );

  // window bounds, all relative to the sync leading edge
  always_comb begin
    win_pos[W_HS] = hc; win_lo[W_HS] = '0;
    win_hi[W_HS]  = ext(cfg[RG_HSW]) + CW'(OFS_HSYNC);
    win_pos[W_HB] = hc; win_lo[W_HB] = ext(cfg[RG_HBS]) + CW'(OFS_HBORD);
    win_hi[W_HB]  = ext(cfg[RG_HBE]) + CW'(OFS_HBORD);
    win_pos[W_HD] = hc; win_lo[W_HD] = hds_pos;
    win_hi[W_HD]  = ext(cfg[RG_HDE]) + CW'(OFS_HDISP);
    win_pos[W_HC] = hc; win_lo[W_HC] = hcur_lo;
    win_hi[W_HC]  = hcur_lo + CW'(CUR_W);
    win_pos[W_VS] = vc; win_lo[W_VS] = '0;
    win_hi[W_VS]  = ext(cfg[RG_VSW]) + CW'(OFS_VERT);
    win_pos[W_VB] = vc; win_lo[W_VB] = ext(cfg[RG_VBS]) + CW'(OFS_VERT);
    win_hi[W_VB]  = ext(cfg[RG_VBE]) + CW'(OFS_VERT);
    win_pos[W_VD] = vc; win_lo[W_VD] = vds_pos;
    win_hi[W_VD]  = ext(cfg[RG_VDE]) + CW'(OFS_VERT);
    win_pos[W_VC] = vc; win_lo[W_VC] = ext(cfg[RG_VCS]) + CW'(OFS_VERT);
    win_hi[W_VC]  = ext(cfg[RG_VCE]) + CW'(OFS_VERT);
  end

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    rtg_window #(.W(CW)) u_win (
      .pos(win_pos[w]), .lo(win_lo[w]), .hi(win_hi[w]), .open(win_open[w])
    );
  end

  logic disp_next;
  assign disp_next = video_run && win_open[W_HD] && win_open[W_VD];

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync       <= 1'b0;
      vsync       <= 1'b0;
      border_en   <= 1'b0;
      disp_en     <= 1'b0;
      cursor_win  <= 1'b0;
      frame_pulse <= 1'b0;
      pix_x       <= '0;
      pix_y       <= '0;
    end else begin
      hsync       <= (video_run && win_open[W_HS]) ^ hsync_neg;
      vsync       <= (video_run && win_open[W_VS]) ^ vsync_neg;
      border_en   <= video_run && win_open[W_HB] && win_open[W_VB];
      disp_en     <= disp_next;
      cursor_win  <= video_run && win_open[W_HC] && win_open[W_VC];
      frame_pulse <= video_run && (hc == '0) && (vc == '0);
      pix_x       <= disp_next ? hc - hds_pos : '0;
      pix_y       <= disp_next ? vc - vds_pos : '0;
    end
  end
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker #(
  parameter int CW = 13
) (
  input logic          clk,
  input logic          rst,
  input logic          video_run,
  input logic          hsync_neg,
  input logic          vsync_neg,
  input logic          hsync,
  input logic          vsync,
  input logic          border_en,
  input logic          disp_en,
  input logic          cursor_win,
  input logic          frame_pulse,
  input logic [CW-1:0] pix_x,
  input logic [CW-1:0] pix_y
);
  // R1: stopped video blanks every window one cycle later
  p_stop_blanks_r1: assert property (@(posedge clk) disable iff (rst)
    !video_run |=> (!border_en && !disp_en && !cursor_win && !frame_pulse));

  // R7: coordinates are zero outside the display window
  p_pix_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !disp_en |-> (pix_x == '0 && pix_y == '0));

  // R8: at frame start both syncs sit at their active level
  p_sync_at_start_r8: assert property (@(posedge clk) disable iff (rst)
    frame_pulse |-> ((hsync != $past(hsync_neg)) && (vsync != $past(vsync_neg))));

  // R9: the frame pulse lasts one cycle
  p_pulse_single_r9: assert property (@(posedge clk) disable iff (rst)
    frame_pulse |=> !frame_pulse);
endmodule

bind raster_timing_gen rtg_checker #(.CW(CW)) u_rtg_checker (
  .clk(clk), .rst(rst), .video_run(video_run), .hsync_neg(hsync_neg),
  .vsync_neg(vsync_neg), .hsync(hsync), .vsync(vsync), .border_en(border_en),
  .disp_en(disp_en), .cursor_win(cursor_win), .frame_pulse(frame_pulse),
  .pix_x(pix_x), .pix_y(pix_y)
);

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;
  localparam int CLK_P = 10;
  localparam int DW    = 12;
  localparam int CW    = DW + 1;
  localparam int CUR_W = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic          video_run = 1'b0;
  logic          hsync_neg = 1'b0;
  logic          vsync_neg = 1'b0;
  logic          hsync, vsync, border_en, disp_en, cursor_win, frame_pulse;
  logic [CW-1:0] pix_x, pix_y;

  raster_timing_gen #(.DW(DW), .CUR_W(CUR_W)) u_raster_timing_gen (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .video_run(video_run), .hsync_neg(hsync_neg),
    .vsync_neg(vsync_neg), .hsync(hsync), .vsync(vsync),
    .border_en(border_en), .disp_en(disp_en), .cursor_win(cursor_win),
    .frame_pulse(frame_pulse), .pix_x(pix_x), .pix_y(pix_y)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;
  int raw [15];
  int e_ht, e_hsw, e_hbs, e_hds, e_hde, e_hbe, e_hcs;
  int e_vt, e_vsw, e_vbs, e_vds, e_vde, e_vbe, e_vcs, e_vce;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // true positions derived from R2, R3, R4, R6
  task automatic apply_expect();
    e_ht  = (raw[0] & ~3) + 8;  e_hsw = (raw[1] & ~1) + 8;
    e_hbs = (raw[2] & ~1) + 12; e_hds = (raw[3] & ~1) + 18;
    e_hde = (raw[4] & ~1) + 18; e_hbe = (raw[5] & ~1) + 12;
    e_hcs = raw[6] + 17;
    e_vt  = raw[7] + 1;  e_vsw = raw[8] + 1;  e_vbs = raw[9] + 1;
    e_vds = raw[10] + 1; e_vde = raw[11] + 1; e_vbe = raw[12] + 1;
    e_vcs = raw[13] + 1; e_vce = raw[14] + 1;
  endtask

  task automatic wr(input int a, input int v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = DW'(v); raw[a] = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic check_blank(input string tag, input int ncyc);
    for (int i = 0; i < ncyc; i++) begin
      chk({tag, " R1 hsync"}, int'(hsync), int'(hsync_neg));
      chk({tag, " R1 vsync"}, int'(vsync), int'(vsync_neg));
      chk({tag, " R1 border"}, int'(border_en), 0);
      chk({tag, " R1 disp"}, int'(disp_en), 0);
      chk({tag, " R1 cursor"}, int'(cursor_win), 0);
      chk({tag, " R1 pulse"}, int'(frame_pulse), 0);
      chk({tag, " R1 pix"}, int'(pix_x) + int'(pix_y), 0);
      @(negedge clk);
    end
  endtask

  // Compare every cycle of nfr frames; optional write at cycle kw of frame 0.
  task automatic run_frames(input string pfx, input int nfr,
                            input int kw, input int wa, input int wv);
    int to = 0;
    while (frame_pulse !== 1'b1 && to < 4000) begin
      @(negedge clk); to++;
    end
    if (to >= 4000) begin
      chk({pfx, " R9 frame start seen"}, 0, 1);
      return;
    end
    for (int f = 0; f < nfr; f++) begin
      int fsz;
      apply_expect();
      fsz = e_ht * e_vt;
      for (int k = 0; k < fsz; k++) begin
        int hc, vc, ed;
        hc = k % e_ht; vc = k / e_ht;
        if (f == 0 && k == kw) begin
          cfg_we = 1'b1; cfg_addr = 4'(wa); cfg_wdata = DW'(wv); raw[wa] = wv;
        end else begin
          cfg_we = 1'b0;
        end
        ed = int'(hc >= e_hds && hc < e_hde && vc >= e_vds && vc < e_vde);
        chk({pfx, hsync_neg ? " R8 hsync" : " R2 hsync"}, int'(hsync),
            int'(hc < e_hsw) ^ int'(hsync_neg));
        chk({pfx, vsync_neg ? " R8 vsync" : " R4 vsync"}, int'(vsync),
            int'(vc < e_vsw) ^ int'(vsync_neg));
        chk({pfx, " R3 R5 border"}, int'(border_en),
            int'(hc >= e_hbs && hc < e_hbe && vc >= e_vbs && vc < e_vbe));
        chk({pfx, " R5 disp"}, int'(disp_en), ed);
        chk({pfx, " R6 cursor"}, int'(cursor_win),
            int'(hc >= e_hcs && hc < e_hcs + CUR_W && vc >= e_vcs && vc < e_vce));
        chk({pfx, " R9 pulse"}, int'(frame_pulse), int'(k == 0));
        chk({pfx, " R7 pix_x"}, int'(pix_x), ed ? hc - e_hds : 0);
        chk({pfx, " R7 pix_y"}, int'(pix_y), ed ? vc - e_vds : 0);
        @(negedge clk);
      end
    end
    cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_blank("reset", 4);
  endtask

  // R10: writes while stopped apply at once; R2..R7, R9 over two frames
  task automatic t_basic();
    wr(0, 56); wr(1, 0);  wr(2, 0);  wr(3, 2);  wr(4, 34);
    wr(5, 46); wr(6, 13); wr(7, 9);  wr(8, 0);  wr(9, 1);
    wr(10, 2); wr(11, 6); wr(12, 7); wr(13, 3); wr(14, 4);
    wr(15, 4095);
    @(negedge clk); video_run = 1'b1;
    run_frames("basic R10", 2, -1, 0, 0);
    @(negedge clk); video_run = 1'b0;
    @(negedge clk);
  endtask

  // R3 alignment: unaligned values give the same geometry
  task automatic t_align();
    wr(0, 59); wr(1, 1); wr(3, 3); wr(4, 35);
    @(negedge clk); video_run = 1'b1;
    run_frames("align R2 R3", 1, -1, 0, 0);
    @(negedge clk); video_run = 1'b0;
    @(negedge clk);
  endtask

  // R8 inverted syncs
  task automatic t_polarity();
    hsync_neg = 1'b1; vsync_neg = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check_blank("stopped inverted", 2);
    video_run = 1'b1;
    run_frames("polarity", 1, -1, 0, 0);
    @(negedge clk); video_run = 1'b0;
    hsync_neg = 1'b0; vsync_neg = 1'b0;
    @(negedge clk);
  endtask

  // R10 mid-frame write is deferred to the next frame
  task automatic t_deferred();
    @(negedge clk); video_run = 1'b1;
    run_frames("deferred R10", 2, 100, 3, 6);
    run_frames("deferred R10 after", 1, -1, 0, 0);
  endtask

  // R1 stopping mid-frame blanks on the next cycle
  task automatic t_stop();
    repeat (37) @(negedge clk);
    video_run = 1'b0;
    @(negedge clk);
    check_blank("stop", 5);
  endtask

  initial begin
    for (int i = 0; i < 15; i++) raw[i] = 0;
    t_reset();
    t_basic();
    t_align();
    t_polarity();
    t_deferred();
    t_stop();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000 && !done) begin
        done = 1;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
      end
    end
  end
endmodule